// File: doc/BRIEF.md
# MSI receive interrupt controller

This block turns inbound message-signalled interrupt writes into pending interrupt bits for a PCIe root-complex style core. Software programs a 64-bit target address through two 32-bit registers. Every inbound write whose address equals that target, and whose data is a legal vector number, sets one pending bit. The data value is the vector number itself.

Pending bits are grouped into banks of 32. Each bank has a status register and an enable register on a simple register port. Reads are combinational and writes take effect at the clock edge. Status bits are cleared by writing ones to them. A single interrupt line is raised while any pending bit is also enabled.

Top module: `msi_rx_ctrl`

## Requirements
- R1: Vector v sets bit v%32 of bank v/32, and no other bit. With 4 banks, vector 70 lands in bank 2 at bit 6 and vector 127 lands in bank 3 at bit 31.
- R2: Bank i has its status register at byte offset 0x10+12·i and its enable register at 0x14+12·i. The third word of each bank, at 0x18+12·i, reads zero. Enable registers read back the value that was written to them.
- R3: The low half of the target address is at offset 0x00 and the high half is at offset 0x04. Both read back what was written. A zero high half means a 32-bit target, and a nonzero high half is also matched.
- R4: An inbound write whose address equals the target and whose data is below the vector count sets that vector's status bit. The bit is readable from the cycle after the write.
- R5: Writing a value to a status register clears each status bit that is 1 in that value. A status bit that is 0 in the written value keeps its state.
- R6: The interrupt output is 1 exactly when some status bit has its enable bit set. A vector whose enable bit is clear still records its status bit, but that bit does not drive the output.
- R7: An inbound write whose address differs from the target in either half leaves all status bits unchanged.
- R8: An inbound write whose data is at or beyond the vector count (128 by default) leaves all status bits unchanged.
- R9: When a message sets a bit in the same cycle that software clears the same bit, the bit ends up set. Other bits cleared in that write still clear.
- R10: Reset clears every status, enable and target address register, and the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Inbound memory write present this cycle |
| msg_addr | input | 64 | Address of the inbound write |
| msg_data | input | 32 | Data of the inbound write (vector number) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_out | output | 1 | Combined interrupt |

## Verification
Two functions can land on the same status bit in one clock: a matching inbound message setting the bit, and a software write-one-to-clear to that bank. The bench drives a message for vector 3 together with a clear of bits 3 and 4 of bank 0. It then reads bank 0 and expects bit 3 still set and bit 4 cleared. A checker also asserts on every cycle that a bit set by a message is present in the next cycle, whatever clear was applied in the same cycle.

// File: rtl/msi_rx_pkg.sv
package msi_rx_pkg;
  localparam int unsigned BANK_W        = 32;
  localparam int unsigned REG_STRIDE    = 12;
  localparam int unsigned OFS_TGT_LO    = 0;
  localparam int unsigned OFS_TGT_HI    = 4;
  localparam int unsigned OFS_STAT_BASE = 16;
  localparam int unsigned OFS_EN_BASE   = 20;

  function automatic int unsigned stat_offset(input int unsigned bank);
    return OFS_STAT_BASE + REG_STRIDE * bank;
  endfunction

  function automatic int unsigned en_offset(input int unsigned bank);
    return OFS_EN_BASE + REG_STRIDE * bank;
  endfunction

  function automatic int unsigned vec_bank(input int unsigned vec);
    return vec / BANK_W;
  endfunction

  function automatic int unsigned vec_bit(input int unsigned vec);
    return vec % BANK_W;
  endfunction
endpackage

// File: rtl/msi_target_match.sv
module msi_target_match #(
  parameter int unsigned NUM_VEC = 128,
  localparam int unsigned VEC_W  = $clog2(NUM_VEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [31:0]      wdata,
  input  logic             msg_valid,
  input  logic [63:0]      msg_addr,
  input  logic [31:0]      msg_data,
  output logic [31:0]      tgt_lo,
  output logic [31:0]      tgt_hi,
  output logic             msg_hit,
  output logic [VEC_W-1:0] msg_vec
);
  logic addr_eq;
  logic data_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_lo <= '0;
      tgt_hi <= '0;
    end else begin
      if (wr_lo) tgt_lo <= wdata;
      if (wr_hi) tgt_hi <= wdata;
    end
  end

  assign addr_eq = (msg_addr == {tgt_hi, tgt_lo});
  assign data_ok = (msg_data < 32'(NUM_VEC));
  assign msg_hit = msg_valid && addr_eq && data_ok;
  assign msg_vec = msg_data[VEC_W-1:0];
endmodule

// File: rtl/msi_bank.sv
module msi_bank #(
  parameter int unsigned BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] set_mask,
  input  logic [BANK_W-1:0] clr_mask,
  input  logic              en_wr,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] status,
  output logic [BANK_W-1:0] enable,
  output logic              pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= (status & ~clr_mask) | set_mask;
      if (en_wr) enable <= wdata;
    end
  end

  assign pend = |(status & enable);
endmodule

// File: rtl/msi_rx_ctrl.sv
module msi_rx_ctrl
  import msi_rx_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned REG_AW    = 8,
  localparam int unsigned NUM_VEC  = NUM_BANKS * BANK_W,
  localparam int unsigned VEC_W    = $clog2(NUM_VEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  input  logic [63:0]       msg_addr,
  input  logic [31:0]       msg_data,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_out
);
  logic [31:0]          tgt_lo;
  logic [31:0]          tgt_hi;
  logic                 msg_hit;
  logic [VEC_W-1:0]     msg_vec;
  logic [NUM_VEC-1:0]   set_all;
  logic [NUM_VEC-1:0]   clr_all;
  logic [NUM_VEC-1:0]   status_all;
  logic [NUM_VEC-1:0]   enable_all;
  logic [NUM_BANKS-1:0] pend;

  msi_target_match #(.NUM_VEC(NUM_VEC)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lo    (reg_we && reg_addr == REG_AW'(OFS_TGT_LO)),
    .wr_hi    (reg_we && reg_addr == REG_AW'(OFS_TGT_HI)),
    .wdata    (reg_wdata),
    .msg_valid(msg_valid),
    .msg_addr (msg_addr),
    .msg_data (msg_data),
    .tgt_lo   (tgt_lo),
    .tgt_hi   (tgt_hi),
    .msg_hit  (msg_hit),
    .msg_vec  (msg_vec)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic stat_wr;
    logic en_wr;
    logic here;

    assign stat_wr = reg_we && (reg_addr == REG_AW'(stat_offset(b)));
    assign en_wr   = reg_we && (reg_addr == REG_AW'(en_offset(b)));
    assign here    = msg_hit && (vec_bank(int'(msg_vec)) == b);
    assign set_all[b*BANK_W +: BANK_W] =
      here ? (BANK_W'(1) << vec_bit(int'(msg_vec))) : '0;
    assign clr_all[b*BANK_W +: BANK_W] = stat_wr ? reg_wdata : '0;

    msi_bank #(.BANK_W(BANK_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_mask(set_all[b*BANK_W +: BANK_W]),
      .clr_mask(clr_all[b*BANK_W +: BANK_W]),
      .en_wr   (en_wr),
      .wdata   (reg_wdata),
      .status  (status_all[b*BANK_W +: BANK_W]),
      .enable  (enable_all[b*BANK_W +: BANK_W]),
      .pend    (pend[b])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == REG_AW'(OFS_TGT_LO)) reg_rdata = tgt_lo;
    if (reg_addr == REG_AW'(OFS_TGT_HI)) reg_rdata = tgt_hi;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (reg_addr == REG_AW'(stat_offset(b)))
        reg_rdata = status_all[b*BANK_W +: BANK_W];
      if (reg_addr == REG_AW'(en_offset(b)))
        reg_rdata = enable_all[b*BANK_W +: BANK_W];
    end
  end

  assign irq_out = |pend;
endmodule

// File: rtl/msi_rx_ctrl_chk.sv
module msi_rx_ctrl_chk #(
  parameter int unsigned NUM_VEC = 128
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_VEC-1:0] set_all,
  input logic [NUM_VEC-1:0] clr_all,
  input logic [NUM_VEC-1:0] status_all,
  input logic [NUM_VEC-1:0] enable_all,
  input logic               irq_out
);
  assert_single_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_all));

  assert_set_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_all != '0) |=> ((status_all & $past(set_all)) == $past(set_all)));

  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all != '0) |=> ((status_all & $past(clr_all) & ~$past(set_all)) == '0));

  assert_quiet_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_all == '0 && clr_all == '0) |=> $stable(status_all));

  assert_irq_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (enable_all != '0 && status_all != '0));
endmodule

bind msi_rx_ctrl msi_rx_ctrl_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .set_all   (set_all),
  .clr_all   (clr_all),
  .status_all(status_all),
  .enable_all(enable_all),
  .irq_out   (irq_out)
);

// File: tb/test_msi_rx_ctrl.sv
module test_msi_rx_ctrl;
  localparam int PERIOD = 10;
  localparam logic [31:0] TLO = 32'hFEE0_0000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        msg_valid = 0;
  logic [63:0] msg_addr = '0;
  logic [31:0] msg_data = '0;
  logic        reg_we = 0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  msi_rx_ctrl i_msi_rx_ctrl (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_addr(msg_addr),
    .msg_data(msg_data), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  function automatic logic [7:0] st(input int b); return 8'(16 + 12*b); endfunction
  function automatic logic [7:0] en(input int b); return 8'(20 + 12*b); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic send_msg(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk); msg_valid = 1; msg_addr = a; msg_data = d;
    @(negedge clk); msg_valid = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    reg_read(8'h00, d); check("R10 tgt_lo", d, 0);
    reg_read(8'h04, d); check("R10 tgt_hi", d, 0);
    reg_read(st(0), d); check("R10 status0", d, 0);
    reg_read(en(3), d); check("R10 enable3", d, 0);
    check("R10 irq", 32'(irq_out), 0);
  endtask

  task automatic t_target;
    logic [31:0] d;
    reg_write(8'h00, TLO);
    reg_read(8'h00, d); check("R3 lo readback", d, TLO);
    reg_read(8'h04, d); check("R3 hi zero", d, 0);
  endtask

  task automatic t_set_and_irq;
    logic [31:0] d;
    send_msg({32'h0, TLO}, 5);
    reg_read(st(0), d); check("R4 vec5 status", d, 32'h20);
    check("R6 disabled no irq", 32'(irq_out), 0);
    reg_write(en(0), 32'h40);
    check("R6 other enable no irq", 32'(irq_out), 0);
    reg_write(en(0), 32'h20);
    check("R6 enabled irq", 32'(irq_out), 1);
    reg_read(en(0), d); check("R2 enable readback", d, 32'h20);
  endtask

  task automatic t_banks;
    logic [31:0] d;
    send_msg({32'h0, TLO}, 70);
    reg_read(st(2), d); check("R1 vec70 bank2", d, 32'h40);
    reg_read(st(1), d); check("R1 bank1 untouched", d, 0);
    reg_read(8'h30, d); check("R2 third word zero", d, 0);
    reg_write(en(2), 32'hA5A5_0F0F);
    reg_read(8'h2C, d); check("R2 enable2 offset", d, 32'hA5A5_0F0F);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    reg_write(st(0), 32'h0);
    reg_read(st(0), d); check("R5 zero write keeps", d, 32'h20);
    reg_write(st(0), 32'hFFFF_FFDF);
    reg_read(st(0), d); check("R5 unselected keep", d, 32'h20);
    reg_write(st(0), 32'h20);
    reg_read(st(0), d); check("R5 w1c", d, 0);
    reg_read(st(2), d); check("R5 other bank kept", d, 32'h40);
    check("R6 irq low after clear", 32'(irq_out), 0);
  endtask

  task automatic t_mismatch;
    logic [31:0] d;
    send_msg({32'h0, TLO + 32'h4}, 9);
    reg_read(st(0), d); check("R7 lo mismatch", d, 0);
    reg_write(8'h04, 32'h1);
    send_msg({32'h0, TLO}, 9);
    reg_read(st(0), d); check("R7 hi mismatch", d, 0);
    send_msg({32'h1, TLO}, 9);
    reg_read(st(0), d); check("R3 64bit match", d, 32'h200);
    reg_write(st(0), 32'h200);
  endtask

  task automatic t_range;
    logic [31:0] d;
    send_msg({32'h1, TLO}, 128);
    reg_read(st(0), d); check("R8 128 ignored b0", d, 0);
    reg_read(st(3), d); check("R8 128 ignored b3", d, 0);
    send_msg({32'h1, TLO}, 32'h8000_0001);
    reg_read(st(0), d); check("R8 huge ignored", d, 0);
    send_msg({32'h1, TLO}, 127);
    reg_read(st(3), d); check("R1 vec127", d, 32'h8000_0000);
    reg_write(en(3), 32'h8000_0000);
    check("R6 bank3 irq", 32'(irq_out), 1);
    reg_write(st(3), 32'h8000_0000);
  endtask

  task automatic t_race;
    logic [31:0] d;
    send_msg({32'h1, TLO}, 3);
    send_msg({32'h1, TLO}, 4);
    reg_read(st(0), d); check("R4 two bits", d, 32'h18);
    @(negedge clk);
    msg_valid = 1; msg_addr = {32'h1, TLO}; msg_data = 3;
    reg_we = 1; reg_addr = st(0); reg_wdata = 32'h18;
    @(negedge clk);
    msg_valid = 0; reg_we = 0;
    reg_read(st(0), d); check("R9 set wins", d, 32'h08);
  endtask

  task automatic t_reset_again;
    logic [31:0] d;
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    reg_read(st(0), d); check("R10 status cleared", d, 0);
    reg_read(en(2), d); check("R10 enable cleared", d, 0);
    reg_read(8'h00, d); check("R10 target cleared", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_target;
    t_set_and_irq;
    t_banks;
    t_clear;
    t_mismatch;
    t_range;
    t_race;
    t_reset_again;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule